// File: doc/BRIEF.md
# BCD Time-of-Day Clock with Alarm

This block keeps wall-clock time in packed BCD: tenths of a second, seconds, minutes and a 12-hour hour field with a PM flag. Its time base is a single-cycle pulse that arrives once per mains cycle. A prescaler turns these pulses into tenth-of-second steps and divides by 5 for 50 Hz mains or by 6 for 60 Hz mains. Software reaches the clock through a small register bus. A side bit decides whether a write lands in the live time or in a write-only alarm copy of the same layout.

Two rules keep multi-byte access consistent. A read of the hours register captures the whole time into a snapshot. Later reads of the time registers return that snapshot until the tenths register is read, while the live count keeps running underneath. A write to the hours register stops the clock. It stays stopped until the tenths register is written, which also restarts the prescaler. After reset the clock is stopped at 1:00:00.0 AM. Whenever a step makes the live time equal to the alarm time, a sticky flag is set and drives the interrupt output. Reading the status register clears the flag.

Top module: `tod_clock`

## Requirements
- R1: After reset the time reads 1:00:00.0 AM (hours register 0x01, all others 0x00), `alarm_irq` is 0, and the clock is stopped: mains pulses do not advance it.
- R2: While running, the time advances by one tenth on every 5th mains pulse when `sel_60hz`=0 and on every 6th pulse when `sel_60hz`=1.
- R3: Register addresses are 0 tenths (BCD in bits 3:0), 1 seconds, 2 minutes (BCD in bits 6:0), 3 hours (BCD 1..12 in bits 4:0, PM in bit 7) and 4 status (alarm flag in bit 0). Tenths wrap 9 to 0 and carry into seconds; seconds and minutes wrap 59 to 00 and carry upward.
- R4: Hours count 12, 1, 2 .. 11. PM toggles only on the step from 11 to 12; the step from 12 to 1 leaves PM unchanged; 09 is followed by 10.
- R5: A bus read of address 3 captures the time. Until address 0 is read, reads of addresses 0..3 return the captured values, while the live time keeps advancing.
- R6: A read of address 0 returns the captured tenths and releases the capture. Reads of addresses 1, 2 and 4 neither capture nor release.
- R7: A time write to address 3 stops the clock. A time write to address 0 restarts it and clears the prescaler, so the next step comes a full division period later.
- R8: With `wr_alarm`=1, writes to addresses 0..3 load the alarm registers, leave the time and the run state unchanged, and cannot be read back.
- R9: When a step makes the time equal to the alarm time, including a time whose seconds and tenths are zero, the alarm flag and `alarm_irq` go to 1 at that clock edge. They stay at 1 until a status read. A match in the same cycle as a status read leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mains_tick | input | 1 | One-cycle pulse per mains cycle |
| sel_60hz | input | 1 | Prescaler select: 0 divides by 5, 1 divides by 6 |
| wr_alarm | input | 1 | Writes target the alarm registers when 1 |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; side effects take place at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address, valid in the same cycle |
| alarm_irq | output | 1 | Sticky alarm interrupt |

## Verification
The alarm flag has two writers: the compare sets it on a step, and a status read clears it. Both can act at the same clock edge. The bench loads a time one tenth short of the alarm and gives all but the last pulse of the division. It then raises the final mains pulse and a status read in the same cycle. That status read must return 0, because the flag has not yet been set. Afterwards `alarm_irq` must be 1 and a second status read must return 1, which shows that the set has priority over the clear.

// File: rtl/tod_pkg.sv
package tod_pkg;

  typedef struct packed {
    logic       pm;
    logic [4:0] hr;
    logic [6:0] mn;
    logic [6:0] sc;
    logic [3:0] ts;
  } tod_t;

  localparam logic [2:0] A_TENTHS = 3'd0;
  localparam logic [2:0] A_SECS   = 3'd1;
  localparam logic [2:0] A_MINS   = 3'd2;
  localparam logic [2:0] A_HOURS  = 3'd3;
  localparam logic [2:0] A_STATUS = 3'd4;

  localparam tod_t RESET_TIME = '{pm: 1'b0, hr: 5'h01, mn: 7'h00, sc: 7'h00, ts: 4'h0};

  // one BCD digit step with carry out
  function automatic logic [4:0] digit_inc(logic [3:0] d);
    if (d == 4'h9) return {1'b1, 4'h0};
    return {1'b0, d + 4'h1};
  endfunction

  // two-digit BCD 00..59 step, returns {carry, value}
  function automatic logic [7:0] sexa_inc(logic [6:0] v);
    logic [4:0] lo;
    if (v == 7'h59) return {1'b1, 7'h00};
    lo = digit_inc(v[3:0]);
    if (lo[4]) return {1'b0, v[6:4] + 3'd1, 4'h0};
    return {1'b0, v[6:4], lo[3:0]};
  endfunction

  // 12-hour step, returns {pm, hr}
  function automatic logic [5:0] hour_inc(logic pm, logic [4:0] hr);
    if (hr == 5'h12) return {pm, 5'h01};
    if (hr == 5'h11) return {~pm, 5'h12};
    if (hr == 5'h09) return {pm, 5'h10};
    return {pm, hr + 5'h01};
  endfunction

  function automatic tod_t tod_step(tod_t t);
    tod_t       n;
    logic [4:0] d;
    logic [7:0] s;
    logic [7:0] m;
    logic [5:0] h;
    n = t;
    d = digit_inc(t.ts);
    n.ts = d[3:0];
    if (d[4]) begin
      s = sexa_inc(t.sc);
      n.sc = s[6:0];
      if (s[7]) begin
        m = sexa_inc(t.mn);
        n.mn = m[6:0];
        if (m[7]) begin
          h = hour_inc(t.pm, t.hr);
          n.pm = h[5];
          n.hr = h[4:0];
        end
      end
    end
    return n;
  endfunction

endpackage

// File: rtl/tod_prescaler.sv
module tod_prescaler #(
  parameter int DIV_LO = 5,
  parameter int DIV_HI = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run,
  input  logic use_hi,
  input  logic clr,
  output logic step
);
  localparam int MAXDIV = (DIV_LO > DIV_HI) ? DIV_LO : DIV_HI;
  localparam int CW     = $clog2(MAXDIV + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  assign last = use_hi ? CW'(DIV_HI - 1) : CW'(DIV_LO - 1);
  assign step = run && tick && !clr && (cnt_q >= last);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt_q <= '0;
    else if (run && tick) cnt_q <= (cnt_q >= last) ? '0 : cnt_q + 1'b1;
  end

  // R2
  presc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(MAXDIV));

  // R7
  presc_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !step);
endmodule

// File: rtl/tod_counter.sv
module tod_counter
  import tod_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic       to_alarm,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  input  logic       step,
  output tod_t       now,
  output tod_t       nxt,
  output logic       running,
  output logic       adv,
  output logic       start_pulse
);
  tod_t time_q;
  logic halted_q;
  logic time_wr;

  assign time_wr     = wr && !to_alarm && (addr <= A_HOURS);
  assign start_pulse = time_wr && (addr == A_TENTHS);
  assign nxt         = tod_step(time_q);
  assign adv         = step && !time_wr;
  assign now         = time_q;
  assign running     = !halted_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      time_q   <= RESET_TIME;
      halted_q <= 1'b1;
    end else if (time_wr) begin
      case (addr)
        A_TENTHS: begin time_q.ts <= wdata[3:0]; halted_q <= 1'b0; end
        A_SECS:   time_q.sc <= wdata[6:0];
        A_MINS:   time_q.mn <= wdata[6:0];
        default:  begin time_q.pm <= wdata[7]; time_q.hr <= wdata[4:0]; halted_q <= 1'b1; end
      endcase
    end else if (adv) begin
      time_q <= nxt;
    end
  end

  // R7
  halt_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_q && !time_wr) |=> $stable(time_q));

  // R3
  tenths_bcd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> (nxt.ts <= 4'h9));

  // R4
  hours_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && time_q.hr >= 5'h01 && time_q.hr <= 5'h12) |-> (nxt.hr != 5'h00));
endmodule

// File: rtl/tod_alarm.sv
module tod_alarm
  import tod_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic       to_alarm,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  input  logic       adv,
  input  tod_t       nxt,
  input  logic       clr,
  output logic       flag
);
  tod_t alarm_q;
  logic flag_q;
  logic alarm_wr;
  logic hit;

  assign alarm_wr = wr && to_alarm && (addr <= A_HOURS);
  assign hit      = adv && (nxt == alarm_q);
  assign flag     = flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alarm_q <= '0;
    end else if (alarm_wr) begin
      case (addr)
        A_TENTHS: alarm_q.ts <= wdata[3:0];
        A_SECS:   alarm_q.sc <= wdata[6:0];
        A_MINS:   alarm_q.mn <= wdata[6:0];
        default:  begin alarm_q.pm <= wdata[7]; alarm_q.hr <= wdata[4:0]; end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= hit || (flag_q && !clr);
  end

  // R9
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);

  // R9
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag_q);
endmodule

// File: rtl/tod_readback.sv
module tod_readback
  import tod_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd,
  input  logic [2:0] addr,
  input  tod_t       live,
  input  logic       flag,
  output logic [7:0] rdata,
  output logic       status_rd
);
  tod_t snap_q;
  logic frozen_q;
  tod_t view;

  assign view      = frozen_q ? snap_q : live;
  assign status_rd = rd && (addr == A_STATUS);

  always_comb begin
    case (addr)
      A_TENTHS: rdata = {4'h0, view.ts};
      A_SECS:   rdata = {1'b0, view.sc};
      A_MINS:   rdata = {1'b0, view.mn};
      A_HOURS:  rdata = {view.pm, 2'b00, view.hr};
      A_STATUS: rdata = {7'h00, flag};
      default:  rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frozen_q <= 1'b0;
      snap_q   <= RESET_TIME;
    end else if (rd && addr == A_HOURS && !frozen_q) begin
      frozen_q <= 1'b1;
      snap_q   <= live;
    end else if (rd && addr == A_TENTHS) begin
      frozen_q <= 1'b0;
    end
  end

  // R5
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen_q && !(rd && addr == A_TENTHS)) |=> (frozen_q && $stable(snap_q)));

  // R6
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == A_TENTHS) |=> !frozen_q);
endmodule

// File: rtl/tod_clock.sv
module tod_clock
  import tod_pkg::*;
#(
  parameter int DIV_50 = 5,
  parameter int DIV_60 = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mains_tick,
  input  logic       sel_60hz,
  input  logic       wr_alarm,
  input  logic [2:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       alarm_irq
);
  logic step, running, adv, start_pulse, flag, status_rd;
  tod_t now, nxt;

  tod_prescaler #(.DIV_LO(DIV_50), .DIV_HI(DIV_60)) u_presc (
    .clk(clk), .rst_n(rst_n), .tick(mains_tick), .run(running),
    .use_hi(sel_60hz), .clr(start_pulse), .step(step));

  tod_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .to_alarm(wr_alarm),
    .addr(bus_addr), .wdata(bus_wdata), .step(step), .now(now), .nxt(nxt),
    .running(running), .adv(adv), .start_pulse(start_pulse));

  tod_alarm u_alm (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .to_alarm(wr_alarm),
    .addr(bus_addr), .wdata(bus_wdata), .adv(adv), .nxt(nxt),
    .clr(status_rd), .flag(flag));

  tod_readback u_rb (
    .clk(clk), .rst_n(rst_n), .rd(bus_rd), .addr(bus_addr), .live(now),
    .flag(flag), .rdata(bus_rdata), .status_rd(status_rd));

  assign alarm_irq = flag;

  // R8
  alarm_wr_no_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && wr_alarm && running) |=> running);
endmodule

// File: tb/tb_tod_clock.sv
module tb_tod_clock;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 0, rst_n = 0, mains_tick = 0, sel_60hz = 0, wr_alarm = 0;
  logic [2:0] bus_addr = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic alarm_irq;
  int n_chk = 0, n_bad = 0;

  tod_clock dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); mains_tick = 1;
      @(negedge clk); mains_tick = 0;
    end
  endtask

  task automatic set_time(logic [7:0] h, logic [7:0] m, logic [7:0] s, logic [7:0] t);
    wr(3, h); wr(2, m); wr(1, s); wr(0, t);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(3, d); check("R1 hours", d, 8'h01);
    rd(2, d); check("R1 mins", d, 8'h00);
    rd(1, d); check("R1 secs", d, 8'h00);
    ticks(12);
    rd(0, d); check("R1 stopped tenths", d, 8'h00);
    check("R1 irq", alarm_irq, 1'b0);
  endtask

  task automatic t_divider();
    logic [7:0] d;
    sel_60hz = 0; wr(0, 8'h00);
    ticks(4); rd(0, d); check("R2 50Hz 4 pulses", d, 8'h00);
    ticks(1); rd(0, d); check("R2 50Hz 5 pulses", d, 8'h01);
    sel_60hz = 1;
    ticks(5); rd(0, d); check("R2 60Hz 5 pulses", d, 8'h01);
    ticks(1); rd(0, d); check("R2 60Hz 6 pulses", d, 8'h02);
    sel_60hz = 0;
  endtask

  task automatic t_rollover();
    logic [7:0] d;
    set_time(8'h01, 8'h59, 8'h59, 8'h09);
    ticks(5);
    rd(0, d); check("R3 tenths wrap", d, 8'h00);
    rd(1, d); check("R3 secs wrap", d, 8'h00);
    rd(2, d); check("R3 mins wrap", d, 8'h00);
    rd(0, d); rd(3, d); check("R3 hour carry", d, 8'h02); rd(0, d);
  endtask

  task automatic t_hours();
    logic [7:0] d;
    set_time(8'h11, 8'h59, 8'h59, 8'h09); ticks(5);
    rd(3, d); check("R4 11->12 sets PM", d, 8'h92); rd(0, d);
    set_time(8'h92, 8'h59, 8'h59, 8'h09); ticks(5);
    rd(3, d); check("R4 12->1 keeps PM", d, 8'h81); rd(0, d);
    set_time(8'h09, 8'h59, 8'h59, 8'h09); ticks(5);
    rd(3, d); check("R4 09->10", d, 8'h10); rd(0, d);
  endtask

  task automatic t_freeze();
    logic [7:0] d;
    set_time(8'h01, 8'h00, 8'h00, 8'h03);
    rd(3, d); check("R5 hours capture", d, 8'h01);
    ticks(5);
    rd(1, d); check("R5 frozen secs", d, 8'h00);
    rd(0, d); check("R6 frozen tenths released", d, 8'h03);
    rd(0, d); check("R5 live kept counting", d, 8'h04);
    rd(1, d); ticks(5);
    rd(0, d); check("R6 secs read no capture", d, 8'h05);
  endtask

  task automatic t_halt();
    logic [7:0] d;
    ticks(3);
    wr(3, 8'h01); ticks(10);
    rd(0, d); check("R7 stopped by hours write", d, 8'h05);
    wr(0, 8'h07);
    ticks(4); rd(0, d); check("R7 prescaler cleared", d, 8'h07);
    ticks(1); rd(0, d); check("R7 restarted", d, 8'h08);
  endtask

  task automatic t_alarm();
    logic [7:0] d;
    wr(3, 8'h12); // stop at a known time
    wr_alarm = 1;
    set_time(8'h01, 8'h00, 8'h00, 8'h00);
    wr_alarm = 0;
    rd(3, d); check("R8 alarm write leaves hours", d, 8'h12); rd(0, d);
    check("R8 alarm write leaves tenths", d, 8'h08);
    ticks(5); rd(0, d); check("R8 still stopped", d, 8'h08);
    set_time(8'h12, 8'h59, 8'h59, 8'h09);
    check("R9 no irq before match", alarm_irq, 1'b0);
    ticks(5);
    check("R9 irq at zero-second match", alarm_irq, 1'b1);
    ticks(5);
    check("R9 irq held", alarm_irq, 1'b1);
    rd(4, d); check("R9 status flag", d, 8'h01);
    check("R9 cleared by status read", alarm_irq, 1'b0);
    rd(4, d); check("R9 status cleared", d, 8'h00);
  endtask

  task automatic t_collide();
    logic [7:0] d;
    set_time(8'h12, 8'h59, 8'h59, 8'h09);
    ticks(4);
    @(negedge clk); mains_tick = 1; bus_addr = 4; bus_rd = 1; #1 d = bus_rdata;
    @(negedge clk); mains_tick = 0; bus_rd = 0;
    check("R9 status before collide", d, 8'h00);
    check("R9 set wins over clear", alarm_irq, 1'b1);
    rd(4, d); check("R9 flag after collide", d, 8'h01);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset(); t_divider(); t_rollover(); t_hours();
        t_freeze(); t_halt(); t_alarm(); t_collide();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule